// File: doc/BRIEF.md
# Supply and Tone Controller Register with I2C Target

This block is the host-facing control point of a satellite receiver's antenna supply stage. A two-wire bus master writes one 8-bit control register and reads it back. The block takes the bus clock and data lines as open-drain inputs and drives the data line through a pull-low enable. It oversamples both lines with the system clock. It recognises START and STOP conditions, acknowledges its own address and handles single-byte write transfers and multi-byte read transfers.

Six register bits are writable and appear directly on control outputs: limiting mode, current range, tone enable, line-drop compensation, high-level select and power enable. The two low bits are not stored. They return two live diagnostic flags, over-temperature and overload, and the flags are captured at the moment a read byte is loaded. The register is also decoded into a 2-bit output-level code and a loop-through switch control. A two-bit select input places the device on one of four adjacent bus addresses. Both a power-on reset and an undervoltage input put the register back into its standby value.

Top module: `sup_ctl_i2c`

## Requirements
- R1: The device acknowledges only the 7-bit address {00010, addr_sel_i}. With select 00, the byte 0x10 starts a write and 0x11 starts a read.
- R2: The register layout from bit 7 down to bit 0 is limiting mode, current range, tone enable, compensation, high-level select, power enable, over-temperature flag, overload flag. Bits 1:0 read the flag inputs ot_flag_i (bit 1) and ol_flag_i (bit 0), and writes to those two bits are discarded.
- R3: In a write, the device acknowledges the address and exactly one data byte, and that byte's bits 7:2 update the register. A further data byte in the same transfer is not acknowledged and leaves the register unchanged.
- R4: A read returns the register byte MSB first. A master ACK after the byte causes the byte to be sent again. A master NACK ends the read and releases SDA.
- R5: With rst_ni low (asynchronous) or uvlo_i high (at the next clock), all six stored bits become 0, which gives power disabled and the loop-through switch closed.
- R6: With power enable 0, loop_closed_o is 1 and level_code_o is 00. With power enable 1, loop_closed_o is 0 and level_code_o is {compensation, high-level}: 00 is 13 V, 01 is 18 V, 10 is 14 V and 11 is 19 V.
- R7: The outputs lim_static_o, cur_low_o, tone_on_o, comp_o, vhigh_o and pwr_en_o equal register bits 7, 6, 5, 4, 3 and 2. lim_static_o=1 means static limiting, 0 means pulsed limiting. cur_low_o=1 selects the lower current range.
- R8: The flag values returned in a read byte are those present when that byte was loaded, which is at the address ACK or at the master ACK. A flag that changes during the byte does not alter it.
- R9: For a mismatched address the device gives no ACK, keeps SDA released and ignores all bus traffic until the next START.
- R10: SDA drive changes only while the synchronised SCL is low. The control outputs change only on a completed data-byte write or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| uvlo_i | input | 1 | Undervoltage indication, synchronous clear of the register |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_sel_i | input | 2 | Low two bits of the device address |
| ot_flag_i | input | 1 | Over-temperature diagnostic flag |
| ol_flag_i | input | 1 | Overload diagnostic flag |
| lim_static_o | output | 1 | 1 static current limiting, 0 pulsed |
| cur_low_o | output | 1 | 1 selects the lower current-limit range |
| tone_on_o | output | 1 | Continuous tone enable |
| comp_o | output | 1 | Line-drop compensation select |
| vhigh_o | output | 1 | High output level select |
| pwr_en_o | output | 1 | Power stage enable |
| level_code_o | output | 2 | Decoded output-level code, 00 while disabled |
| loop_closed_o | output | 1 | 1 closes the loop-through switch |

## Verification
The bench uses the default parameters: two synchroniser stages and the five-bit base 00010 with a two-bit select. With these values all four device addresses and the neighbouring non-matching codes can be reached, and the 3-cycle line latency is far below the 20-cycle quarter-bit spacing the bench drives. The vectors reach each level code and both loop-through states, and every flag combination is read back. Directed cases cover an address mismatch, an extra write byte, a repeated read with a flag change in mid-byte, the undervoltage clear and the asynchronous reset.

// File: rtl/sup_ctl_pkg.sv
package sup_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_W = 2;
  localparam int CTRL_W = BYTE_W - FLAG_W;

  // index of each function inside the stored six-bit field
  localparam int C_EN   = 0;
  localparam int C_VHI  = 1;
  localparam int C_COMP = 2;
  localparam int C_TONE = 3;
  localparam int C_CUR  = 4;
  localparam int C_LIM  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_st_e;
endpackage

// File: rtl/sup_ctl_sync.sv
module sup_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  // STAGES for metastability, one more to detect edges
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign q_o    = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/sup_ctl_fsm.sv
module sup_ctl_fsm
  import sup_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-2:0] dev_addr_i,
  input  logic [BYTE_W-1:0] tx_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [CTRL_W-1:0] wdata_o
);
  bus_st_e           st_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              oe_q, rw_q, ack_q, we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      oe_q  <= 1'b0;
      rw_q  <= 1'b0;
      ack_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_i) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise_i && cnt_q < 4'd8) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (sh_q[BYTE_W-1:1] == dev_addr_i) begin
                oe_q <= 1'b1;
                rw_q <= sh_q[0];
                st_q <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q <= tx_i;  // flags captured here
                oe_q <= ~tx_i[BYTE_W-1];
                st_q <= ST_RD;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i && cnt_q < 4'd8) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              we_q <= 1'b1;
              oe_q <= 1'b1;
              st_q <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              oe_q <= 1'b0;
              st_q <= ST_IDLE;  // only one data byte per transfer
            end
          end
          ST_RD: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd7) begin
                oe_q <= 1'b0;
                st_q <= ST_RD_ACK;
              end else begin
                cnt_q <= cnt_q + 4'd1;
                sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                oe_q  <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              ack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (ack_q) begin
                sh_q  <= tx_i;
                oe_q  <= ~tx_i[BYTE_W-1];
                cnt_q <= '0;
                st_q  <= ST_RD;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign we_o     = we_q;
  assign wdata_o  = sh_q[BYTE_W-1:FLAG_W];
endmodule

// File: rtl/sup_ctl_regs.sv
module sup_ctl_regs
  import sup_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uvlo_i,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [1:0]        level_o,
  output logic              loop_closed_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (uvlo_i) ctrl_q <= '0;
    else if (we_i)   ctrl_q <= wdata_i;
  end

  assign ctrl_o        = ctrl_q;
  assign level_o       = ctrl_q[C_EN] ? {ctrl_q[C_COMP], ctrl_q[C_VHI]} : 2'b00;
  assign loop_closed_o = ~ctrl_q[C_EN];
endmodule

// File: rtl/sup_ctl_i2c.sv
module sup_ctl_i2c
  import sup_ctl_pkg::*;
#(
  parameter int                           SYNC_STAGES = 2,
  parameter int                           SEL_W       = 2,
  parameter logic [BYTE_W-2-SEL_W:0]      ADDR_HI     = 5'b00010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             uvlo_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [SEL_W-1:0] addr_sel_i,
  input  logic             ot_flag_i,
  input  logic             ol_flag_i,
  output logic             lim_static_o,
  output logic             cur_low_o,
  output logic             tone_on_o,
  output logic             comp_o,
  output logic             vhigh_o,
  output logic             pwr_en_o,
  output logic [1:0]       level_code_o,
  output logic             loop_closed_o
);
  localparam int LINES = 2;  // 0: clock line, 1: data line

  logic [LINES-1:0] line_raw, line_s, line_rise, line_fall;
  logic             scl_s, start, stop;
  logic             reg_we;
  logic [CTRL_W-1:0] wdata, ctrl_q;
  logic [BYTE_W-1:0] tx_byte;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    sup_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (line_raw[g]),
      .q_o    (line_s[g]),
      .rise_o (line_rise[g]),
      .fall_o (line_fall[g])
    );
  end

  assign scl_s = line_s[0];
  assign start = line_fall[1] & scl_s;
  assign stop  = line_rise[1] & scl_s;

  assign tx_byte = {ctrl_q, ot_flag_i, ol_flag_i};

  sup_ctl_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (line_rise[0]),
    .scl_fall_i (line_fall[0]),
    .sda_i      (line_s[1]),
    .start_i    (start),
    .stop_i     (stop),
    .dev_addr_i ({ADDR_HI, addr_sel_i}),
    .tx_i       (tx_byte),
    .sda_oe_o   (sda_oe_o),
    .we_o       (reg_we),
    .wdata_o    (wdata)
  );

  sup_ctl_regs u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .uvlo_i        (uvlo_i),
    .we_i          (reg_we),
    .wdata_i       (wdata),
    .ctrl_o        (ctrl_q),
    .level_o       (level_code_o),
    .loop_closed_o (loop_closed_o)
  );

  assign lim_static_o = ctrl_q[C_LIM];
  assign cur_low_o    = ctrl_q[C_CUR];
  assign tone_on_o    = ctrl_q[C_TONE];
  assign comp_o       = ctrl_q[C_COMP];
  assign vhigh_o      = ctrl_q[C_VHI];
  assign pwr_en_o     = ctrl_q[C_EN];
endmodule

// File: rtl/sup_ctl_i2c_chk.sv
module sup_ctl_i2c_chk #(
  parameter int CW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          uvlo_i,
  input logic          scl_s,
  input logic          sda_oe_o,
  input logic          reg_we,
  input logic [CW-1:0] ctrl_q
);
  // R10: data-line drive never moves while the clock line is high
  a_r10_sda_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o))
    else $error("a_r10_sda_scl_low");

  // R10: register only moves on a write strobe or undervoltage
  a_r10_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we && !uvlo_i) |=> $stable(ctrl_q))
    else $error("a_r10_ctrl_hold");

  // R5: undervoltage clears the register on the next edge
  a_r5_uvlo_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (ctrl_q == '0))
    else $error("a_r5_uvlo_clear");

  // R3: the write strobe comes from the ACK-slot falling edge
  a_r3_we_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |-> !scl_s)
    else $error("a_r3_we_scl_low");
endmodule

bind sup_ctl_i2c sup_ctl_i2c_chk #(.CW(sup_ctl_pkg::CTRL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .uvlo_i   (uvlo_i),
  .scl_s    (scl_s),
  .sda_oe_o (sda_oe_o),
  .reg_we   (reg_we),
  .ctrl_q   (ctrl_q)
);

// File: tb/sup_ctl_i2c_tb.sv
module sup_ctl_i2c_tb;
  localparam int Q = 20;  // quarter bit in clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic [1:0] sel = 2'b00;
  logic ot = 1'b0, ol = 1'b0;
  logic sda_oe, scl_line, sda_line;
  logic lim_o, cur_o, tone_o, comp_o, vhi_o, en_o, loop_o;
  logic [1:0] lvl_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  assign scl_line = ~m_scl_low;
  assign sda_line = ~(m_sda_low | sda_oe);

  sup_ctl_i2c u_dut (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_i(uvlo),
    .scl_i(scl_line), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(sel), .ot_flag_i(ot), .ol_flag_i(ol),
    .lim_static_o(lim_o), .cur_low_o(cur_o), .tone_on_o(tone_o),
    .comp_o(comp_o), .vhigh_o(vhi_o), .pwr_en_o(en_o),
    .level_code_o(lvl_o), .loop_closed_o(loop_o)
  );

  // {sel[2], wdata[8], flags{ot,ol}[2], exp level[2], exp loop_closed[1]}
  localparam logic [14:0] VEC [8] = '{
    {2'd0, 8'h04, 2'b00, 2'b00, 1'b0},
    {2'd1, 8'h0C, 2'b01, 2'b01, 1'b0},
    {2'd2, 8'h14, 2'b10, 2'b10, 1'b0},
    {2'd3, 8'h1C, 2'b11, 2'b11, 1'b0},
    {2'd0, 8'hFF, 2'b00, 2'b11, 1'b0},
    {2'd1, 8'h18, 2'b01, 2'b00, 1'b1},
    {2'd2, 8'hA6, 2'b01, 2'b00, 1'b0},
    {2'd3, 8'h40, 2'b10, 2'b00, 1'b1}
  };

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  function automatic logic [5:0] outs();
    return {lim_o, cur_o, tone_o, comp_o, vhi_o, en_o};
  endfunction

  task automatic bus_start();
    m_sda_low = 1'b0; wait_q(1);
    m_scl_low = 1'b0; wait_q(1);
    m_sda_low = 1'b1; wait_q(1);
    m_scl_low = 1'b1; wait_q(1);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wait_q(1);
    m_scl_low = 1'b0; wait_q(1);
    m_sda_low = 1'b0; wait_q(2);
  endtask

  task automatic put_bit(input logic b);
    m_sda_low = ~b; wait_q(1);
    m_scl_low = 1'b0; wait_q(2);
    m_scl_low = 1'b1; wait_q(1);
  endtask

  task automatic get_bit(output logic b);
    m_sda_low = 1'b0; wait_q(1);
    m_scl_low = 1'b0; wait_q(1);
    b = sda_line; wait_q(1);
    m_scl_low = 1'b1; wait_q(1);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic ack, input int chg_at, input logic [1:0] chg_val,
                          output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      if (i == chg_at) {ot, ol} = chg_val;
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack);
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d,
                        output logic a_ack, output logic d_ack);
    bus_start();
    put_byte({a, 1'b0}, a_ack);
    put_byte(d, d_ack);
    bus_stop();
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic a_ack, output logic [7:0] d);
    bus_start();
    put_byte({a, 1'b1}, a_ack);
    if (a_ack) get_byte(1'b0, -1, 2'b00, d);
    else d = 8'hxx;
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic aa, da;
    logic [7:0] rd, rd2;
    logic [14:0] v;

    m_scl_low = 1'b0;
    m_sda_low = 1'b0;
    repeat (5) @(negedge clk);
    // R5: reset state
    chk("R5 reset outputs", {outs(), lvl_o, loop_o}, {6'h00, 2'b00, 1'b1});
    chk("R5 reset sda", sda_oe, 1'b0);
    rst_n = 1'b1;
    wait_q(2);

    // R1: literal 0x10/0x11 bytes with select 00
    sel = 2'b00;
    bus_start();
    put_byte(8'h10, aa);
    put_byte(8'h24, da);
    bus_stop();
    chk("R1 write byte 0x10 ack", aa, 1'b1);
    chk("R3 data ack", da, 1'b1);
    bus_start();
    put_byte(8'h11, aa);
    get_byte(1'b0, -1, 2'b00, rd);
    bus_stop();
    chk("R1 read byte 0x11 ack", aa, 1'b1);
    chk("R4 readback", rd, 8'h24);

    // table walk
    for (int k = 0; k < 8; k++) begin
      v = VEC[k];
      sel = v[14:13];
      {ot, ol} = v[4:3];
      wr_reg({5'b00010, v[14:13]}, v[12:5], aa, da);
      chk("R1 address ack", aa, 1'b1);
      chk("R3 data ack", da, 1'b1);
      chk("R7 control outputs", outs(), v[12:7]);
      chk("R6 level code", lvl_o, v[2:1]);
      chk("R6 loop switch", loop_o, v[0]);
      rd_reg({5'b00010, v[14:13]}, aa, rd);
      chk("R2 readback with flags", rd, {v[12:7], v[4:3]});
    end

    // R9: mismatched address; register holds 0x40 pattern
    sel = 2'b00;
    {ot, ol} = 2'b00;
    wr_reg(7'b0001001, 8'hFC, aa, da);
    chk("R9 neighbour address nack", aa, 1'b0);
    chk("R9 following byte nack", da, 1'b0);
    chk("R9 register unchanged", outs(), 6'b010000);
    wr_reg(7'b1001000, 8'hFC, aa, da);
    chk("R9 far address nack", aa, 1'b0);
    chk("R9 register unchanged 2", outs(), 6'b010000);

    // R3: second data byte not acked, register keeps first
    bus_start();
    put_byte(8'h10, aa);
    put_byte(8'h2C, da);
    put_byte(8'hD0, aa);
    bus_stop();
    chk("R3 first byte ack", da, 1'b1);
    chk("R3 extra byte nack", aa, 1'b0);
    chk("R3 extra byte ignored", outs(), 6'b001011);

    // R4/R8: repeated read, flags change mid-byte
    {ot, ol} = 2'b00;
    bus_start();
    put_byte(8'h11, aa);
    get_byte(1'b1, 4, 2'b11, rd);
    get_byte(1'b0, -1, 2'b11, rd2);
    bus_stop();
    chk("R8 first byte old flags", rd, 8'h2C);
    chk("R4 R8 second copy new flags", rd2, 8'h2F);
    chk("R4 sda released after nack", sda_oe, 1'b0);

    // R5: undervoltage pulse
    uvlo = 1'b1;
    @(negedge clk);
    uvlo = 1'b0;
    chk("R5 uvlo clears", {outs(), lvl_o, loop_o}, {6'h00, 2'b00, 1'b1});
    rd_reg(7'b0001000, aa, rd);
    chk("R5 R2 readback after uvlo", rd, 8'h03);

    // R5: asynchronous reset
    wr_reg(7'b0001000, 8'hE4, aa, da);
    chk("R7 pre-reset value", outs(), 6'b111001);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R5 async reset", {outs(), loop_o}, {6'h00, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
    wait_q(1);

    summary();
    $finish;
  end
endmodule